// File: doc/BRIEF.md
# Page Buffer Write-Back Filter

This controller manages a page-granular DRAM buffer placed in front of a slow, wear-limited non-volatile main memory. It keeps a direct-mapped tag store of resident pages, with a 16-bit per-line dirty mask for each frame. It observes every processor line access and decides whether the line hits in the buffer or whether a page has to be brought in from backing storage. Data arrays and device timing sit elsewhere. This block only makes the bookkeeping decisions and drives the handshakes.

A miss asks the backing storage for the page and installs it into the buffer only. The non-volatile memory gets no write at install time. When the frame chosen for the new page holds a victim with dirty lines, the controller first drains exactly those lines into a write queue toward the non-volatile memory. It issues them in ascending line order, one per cycle whenever the queue has room. Writes flagged as streaming never mark lines dirty, so they generate no write-back traffic. While a drain runs, the block reports busy and takes no new requests.

Top module: `pbuf_wb_filter`

## Requirements
- R1: After reset every frame is invalid. `req_ready_o` is 1, and `busy_o`, `wq_valid_o`, `fill_req_o` and `done_o` are 0. The first access to any page misses.
- R2: An accepted request whose page is resident pulses `done_o` with `hit_o`=1 in the cycle after acceptance, and it raises no fill request.
- R3: A non-streaming write hit sets the dirty bit of the addressed line, and that line is written back when the page is later evicted.
- R4: On a miss whose frame is invalid or clean, no write-queue entry is issued. `fill_req_o` rises in the cycle after acceptance with `fill_page_o` equal to the requested page, and it holds until `fill_done_i` is seen.
- R5: The install on `fill_done_i` writes nothing to the queue. `done_o` pulses with `hit_o`=0 in the following cycle. A non-streaming write miss leaves exactly its own line dirty in the installed page.
- R6: On a miss whose victim has dirty lines, each dirty line is sent to the queue exactly once. The entries go out in ascending line order (line index 0 to 15 on `wq_line_o`), they carry the victim page number, and they all precede `fill_req_o`.
- R7: While `wq_full_i` is 1, the presented queue entry stays stable and is not consumed. An entry is consumed at a clock edge with `wq_valid_o`=1 and `wq_full_i`=0. No entry is lost or repeated.
- R8: During a drain `busy_o` is 1 and `req_ready_o` is 0. A request presented during the drain is ignored, and it leaves no dirty state behind.
- R9: Writes with `req_stream_i`=1, whether hit or miss, set no dirty bit, so evicting such a page issues no queue entries.
- R10: The frame index is the low log2(FRAMES) bits of the page number. Pages with different indices stay resident together.
- R11: From the acceptance of a miss until its `done_o`, `req_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Line access request |
| req_write_i | input | 1 | Request is a write |
| req_stream_i | input | 1 | Request belongs to streaming traffic |
| req_page_i | input | PAGE_W | Page number of the access |
| req_line_i | input | 4 | Line index within the page |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| done_o | output | 1 | Access completed (one-cycle pulse) |
| hit_o | output | 1 | Completed access was a hit |
| busy_o | output | 1 | Eviction drain in progress |
| fill_req_o | output | 1 | Page fetch request to backing storage |
| fill_page_o | output | PAGE_W | Page to fetch |
| fill_done_i | input | 1 | Page fetched and placed in the buffer |
| wq_valid_o | output | 1 | Write-queue entry presented |
| wq_page_o | output | PAGE_W | Page of the queued line |
| wq_line_o | output | 4 | Line index of the queued line |
| wq_full_i | input | 1 | Write queue cannot take an entry |

## Verification
A corrupted dirty mask or tag stays invisible until the affected frame is evicted. At that point it shows up as missing, extra or misordered write-queue entries, or as a hit or miss that contradicts the access history. The bench therefore ends every dirtying sequence with a conflicting access. It then compares the drained line list entry by entry, starting in the cycle after acceptance. A wrong controller state shows up within one cycle as a fill request overlapping the queue, as ready during a drain, or as a queue entry that changes while the queue is full.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FILL
  } ctl_state_e;
endpackage

// File: rtl/pbuf_tag_store.sv
module pbuf_tag_store #(
  parameter int FRAMES = 4,
  parameter int TAG_W  = 10,
  parameter int LINES  = 16,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  look_idx_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic              vic_valid_o,
  output logic [TAG_W-1:0]  vic_tag_o,
  output logic [LINES-1:0]  vic_dirty_o,
  input  logic              mark_en_i,
  input  logic [LINE_W-1:0] mark_line_i,
  input  logic              inst_en_i,
  input  logic [IDX_W-1:0]  inst_idx_i,
  input  logic [TAG_W-1:0]  inst_tag_i,
  input  logic [LINES-1:0]  inst_dirty_i
);
  logic             valid_q [FRAMES];
  logic [TAG_W-1:0] tag_q   [FRAMES];
  logic [LINES-1:0] dirty_q [FRAMES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < FRAMES; f++) begin
        valid_q[f] <= 1'b0;
        tag_q[f]   <= '0;
        dirty_q[f] <= '0;
      end
    end else begin
      for (int f = 0; f < FRAMES; f++) begin
        if (inst_en_i && inst_idx_i == IDX_W'(f)) begin
          valid_q[f] <= 1'b1;
          tag_q[f]   <= inst_tag_i;
          dirty_q[f] <= inst_dirty_i;
        end else if (mark_en_i && look_idx_i == IDX_W'(f)) begin
          dirty_q[f][mark_line_i] <= 1'b1;
        end
      end
    end
  end

  assign vic_valid_o = valid_q[look_idx_i];
  assign vic_tag_o   = tag_q[look_idx_i];
  assign vic_dirty_o = dirty_q[look_idx_i];
  assign hit_o       = vic_valid_o && (vic_tag_o == look_tag_i);
endmodule

// File: rtl/pbuf_drain.sv
module pbuf_drain #(
  parameter int LINES = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LINES-1:0]  mask_i,
  input  logic              pop_i,
  output logic              last_o,
  output logic [LINE_W-1:0] line_o
);
  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] rest;

  assign rest   = mask_q & (mask_q - LINES'(1));
  assign last_o = (rest == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (load_i) mask_q <= mask_i;
    else if (pop_i)  mask_q <= rest;
  end

  // lowest set bit first
  always_comb begin
    line_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (mask_q[i]) line_o = LINE_W'(i);
    end
  end
endmodule

// File: rtl/pbuf_wb_filter.sv
module pbuf_wb_filter
  import pbuf_pkg::*;
#(
  parameter int PAGE_W = 12,
  parameter int FRAMES = 4,
  parameter int LINES  = 16,
  localparam int IDX_W  = $clog2(FRAMES),
  localparam int TAG_W  = PAGE_W - IDX_W,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_stream_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic [LINE_W-1:0] req_line_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              busy_o,
  output logic              fill_req_o,
  output logic [PAGE_W-1:0] fill_page_o,
  input  logic              fill_done_i,
  output logic              wq_valid_o,
  output logic [PAGE_W-1:0] wq_page_o,
  output logic [LINE_W-1:0] wq_line_o,
  input  logic              wq_full_i
);
  ctl_state_e        state_q;
  logic [PAGE_W-1:0] pend_page_q, vic_page_q;
  logic [LINE_W-1:0] pend_line_q;
  logic              pend_dirty_q, done_q, hit_q;

  logic              lk_hit, vic_valid, accept, miss, pop, last, load;
  logic [TAG_W-1:0]  vic_tag;
  logic [LINES-1:0]  vic_dirty;
  logic              inst_en;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign miss    = accept && !lk_hit;
  assign load    = miss && vic_valid && (vic_dirty != '0);
  assign pop     = (state_q == ST_DRAIN) && !wq_full_i;
  assign inst_en = (state_q == ST_FILL) && fill_done_i;

  pbuf_tag_store #(.FRAMES(FRAMES), .TAG_W(TAG_W), .LINES(LINES)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .look_idx_i  (req_page_i[IDX_W-1:0]),
    .look_tag_i  (req_page_i[PAGE_W-1:IDX_W]),
    .hit_o       (lk_hit),
    .vic_valid_o (vic_valid),
    .vic_tag_o   (vic_tag),
    .vic_dirty_o (vic_dirty),
    .mark_en_i   (accept && lk_hit && req_write_i && !req_stream_i),
    .mark_line_i (req_line_i),
    .inst_en_i   (inst_en),
    .inst_idx_i  (pend_page_q[IDX_W-1:0]),
    .inst_tag_i  (pend_page_q[PAGE_W-1:IDX_W]),
    .inst_dirty_i(pend_dirty_q ? (LINES'(1) << pend_line_q) : '0)
  );

  pbuf_drain #(.LINES(LINES)) u_drain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .mask_i(vic_dirty),
    .pop_i (pop),
    .last_o(last),
    .line_o(wq_line_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_page_q  <= '0;
      pend_line_q  <= '0;
      pend_dirty_q <= 1'b0;
      vic_page_q   <= '0;
      done_q       <= 1'b0;
      hit_q        <= 1'b0;
    end else begin
      done_q <= (accept && lk_hit) || inst_en;
      hit_q  <= accept && lk_hit;
      unique case (state_q)
        ST_IDLE: if (miss) begin
          pend_page_q  <= req_page_i;
          pend_line_q  <= req_line_i;
          pend_dirty_q <= req_write_i && !req_stream_i;
          vic_page_q   <= {vic_tag, req_page_i[IDX_W-1:0]};
          state_q      <= load ? ST_DRAIN : ST_FILL;
        end
        ST_DRAIN: if (pop && last) state_q <= ST_FILL;
        ST_FILL:  if (fill_done_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q == ST_DRAIN);
  assign wq_valid_o  = (state_q == ST_DRAIN);
  assign wq_page_o   = vic_page_q;
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_page_o = pend_page_q;
  assign done_o      = done_q;
  assign hit_o       = hit_q;
endmodule

// File: rtl/pbuf_wb_filter_chk.sv
module pbuf_wb_filter_chk #(
  parameter int PAGE_W = 12,
  parameter int LINES  = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              done_o,
  input logic              busy_o,
  input logic              fill_req_o,
  input logic [PAGE_W-1:0] fill_page_o,
  input logic              fill_done_i,
  input logic              wq_valid_o,
  input logic [PAGE_W-1:0] wq_page_o,
  input logic [LINE_W-1:0] wq_line_o,
  input logic              wq_full_i
);
  a_r7_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wq_valid_o && wq_full_i) |=> (wq_valid_o && $stable(wq_line_o) && $stable(wq_page_o)));

  a_r6_ascending_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wq_valid_o && !wq_full_i) |=> (!wq_valid_o || (wq_line_o > $past(wq_line_o))));

  a_r6_drain_before_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wq_valid_o |-> !fill_req_o);

  a_r8_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!req_ready_o && !done_o));

  a_r4_fill_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_done_i) |=> (fill_req_o && $stable(fill_page_o)));

  a_r11_no_ready_in_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> !req_ready_o);
endmodule

bind pbuf_wb_filter pbuf_wb_filter_chk #(.PAGE_W(PAGE_W), .LINES(LINES)) u_chk (.*);

// File: tb/pbuf_wb_filter_test.sv
module pbuf_wb_filter_test;
  localparam int PAGE_W = 12;
  localparam int FRAMES = 4;
  localparam int LINES  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_stream_i = 0;
  logic [PAGE_W-1:0] req_page_i = '0;
  logic [3:0] req_line_i = '0;
  logic req_ready_o, done_o, hit_o, busy_o, fill_req_o, wq_valid_o;
  logic [PAGE_W-1:0] fill_page_o, wq_page_o;
  logic [3:0] wq_line_o;
  logic fill_done_i = 0, wq_full_i = 0;

  always #2 clk = ~clk;

  pbuf_wb_filter #(.PAGE_W(PAGE_W), .FRAMES(FRAMES), .LINES(LINES)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_stream_i(req_stream_i),
    .req_page_i(req_page_i), .req_line_i(req_line_i), .req_ready_o(req_ready_o),
    .done_o(done_o), .hit_o(hit_o), .busy_o(busy_o),
    .fill_req_o(fill_req_o), .fill_page_o(fill_page_o), .fill_done_i(fill_done_i),
    .wq_valid_o(wq_valid_o), .wq_page_o(wq_page_o), .wq_line_o(wq_line_o),
    .wq_full_i(wq_full_i)
  );

  int n_chk = 0, n_bad = 0;
  bit m_valid [FRAMES];
  logic [PAGE_W-1:0] m_page [FRAMES];
  logic [LINES-1:0] m_dirty [FRAMES];
  logic [PAGE_W-1:0] log_page [64];
  int log_line [64];
  int log_n;
  bit stall_mode = 0;
  bit inject = 0;
  logic [PAGE_W-1:0] inj_page;
  logic [3:0] inj_line;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(int page, int line, bit wr, bit st, string tag);
    int fi = page % FRAMES;
    bit exp_hit = m_valid[fi] && (m_page[fi] == PAGE_W'(page));
    logic [LINES-1:0] exp_mask = (!exp_hit && m_valid[fi]) ? m_dirty[fi] : '0;
    logic [PAGE_W-1:0] vpage = m_page[fi];
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_stream_i = st;
    req_page_i = PAGE_W'(page); req_line_i = 4'(line);
    @(negedge clk);
    req_valid_i = 0;
    log_n = 0;
    if (exp_hit) begin
      check(done_o && hit_o, {tag, " hit done"}, {done_o, hit_o}, 3);
      check(!fill_req_o, {tag, " hit no fill"}, fill_req_o, 0);
    end else begin
      int cyc = 0;
      bit busy_ok = 1;
      bit injected = 0;
      int k = 0;
      while (!fill_req_o && cyc < 200) begin
        if (!busy_o || req_ready_o || !wq_valid_o) busy_ok = 0;
        wq_full_i = stall_mode && (cyc % 2 == 0);
        if (inject && !injected) begin
          req_valid_i = 1; req_write_i = 1; req_stream_i = 0;
          req_page_i = inj_page; req_line_i = inj_line; injected = 1;
        end else req_valid_i = 0;
        if (wq_valid_o && !wq_full_i && log_n < 64) begin
          log_page[log_n] = wq_page_o; log_line[log_n] = int'(wq_line_o); log_n++;
        end
        @(negedge clk);
        cyc++;
      end
      req_valid_i = 0; wq_full_i = 0;
      check(busy_ok, "R8 busy and not ready during drain", busy_ok, 1);
      check(log_n == $countones(exp_mask), {tag, " R6 queue entry count"}, log_n, $countones(exp_mask));
      for (int i = 0; i < LINES; i++) begin
        if (exp_mask[i] && k < log_n) begin
          check(log_line[k] == i && log_page[k] == vpage, "R6 entry line/page order",
                log_line[k], i);
          k++;
        end
      end
      check(fill_page_o == PAGE_W'(page), "R4 fill page", int'(fill_page_o), page);
      check(!req_ready_o && !wq_valid_o, "R11 not ready while fill pending", req_ready_o, 0);
      @(negedge clk);
      check(fill_req_o, "R4 fill request held", fill_req_o, 1);
      fill_done_i = 1;
      @(negedge clk);
      fill_done_i = 0;
      check(done_o && !hit_o, {tag, " R5 install done as miss"}, {done_o, hit_o}, 2);
      check(!fill_req_o && !wq_valid_o, "R5 no write at install", wq_valid_o, 0);
      m_valid[fi] = 1; m_page[fi] = PAGE_W'(page); m_dirty[fi] = '0;
    end
    if (wr && !st) m_dirty[fi][line] = 1'b1;
  endtask

  task automatic t_reset();
    check(req_ready_o && !busy_o && !wq_valid_o && !fill_req_o && !done_o,
          "R1 reset outputs", {req_ready_o, busy_o, wq_valid_o, fill_req_o, done_o}, 16);
    access('h010, 0, 0, 0, "R1 cold miss");
  endtask

  task automatic t_write_hits();
    access('h010, 3, 1, 0, "R2 R3 write hit");
    access('h010, 0, 1, 0, "R3 write hit");
    access('h010, 15, 1, 0, "R3 write hit");
    access('h010, 8, 0, 0, "R2 read hit");
  endtask

  task automatic t_dirty_evict();
    access('h014, 2, 0, 0, "R6 dirty eviction");
  endtask

  task automatic t_write_miss_stall();
    access('h021, 7, 1, 0, "R5 write miss");
    stall_mode = 1;
    access('h025, 0, 0, 0, "R7 eviction under full queue");
    stall_mode = 0;
  endtask

  task automatic t_stream();
    access('h025, 1, 1, 1, "R9 stream write hit");
    access('h025, 2, 1, 1, "R9 stream write hit");
    access('h029, 0, 0, 0, "R9 evict stream page");
    access('h032, 4, 1, 1, "R9 stream write miss");
    access('h036, 0, 0, 0, "R9 evict stream miss page");
  endtask

  task automatic t_busy_ignore();
    access('h013, 0, 0, 0, "R8 setup");
    access('h002, 5, 1, 0, "R8 setup");
    access('h002, 9, 1, 0, "R8 setup hit");
    inj_page = 'h013; inj_line = 4'd9; inject = 1;
    access('h006, 0, 0, 0, "R8 drain with side request");
    inject = 0;
    access('h017, 0, 0, 0, "R8 ignored write left page clean");
  endtask

  task automatic t_direct_map();
    access('h014, 1, 0, 0, "R10 frame0 resident");
    access('h029, 1, 0, 0, "R10 frame1 resident");
    access('h006, 1, 0, 0, "R10 frame2 resident");
    access('h017, 1, 0, 0, "R10 frame3 resident");
  endtask

  initial begin
    for (int f = 0; f < FRAMES; f++) begin
      m_valid[f] = 0; m_page[f] = '0; m_dirty[f] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_hits();
    t_dirty_evict();
    t_write_miss_stall();
    t_stream();
    t_busy_ignore();
    t_direct_map();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule